// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

A small synchronous up-counter (four bits by default). All state flops update together on the rising clock edge. The counter has four modes. A parallel load (active low) copies a data word into the state. A clear (active low) returns the state to zero. The counter increments when two count-enable inputs are both high, and holds its value otherwise. A parameter selects how the clear acts: it can act at once, without waiting for the clock, or it can take effect at the next edge. The edge-timed form lets a decode of a terminal count, fed back into the clear, shorten the count to any modulus.

The carry output is high only when the state is all ones and the second enable, the "through" enable, is high. That enable reaches the carry through logic only, with no register in the path. Wider counters are built from several instances on one clock. Each stage's carry drives the next stage's through enable, and a global enable drives the "parallel" enable of every stage. No extra gating is needed between stages.

Top module: `preset_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes 0 on that edge.
- R2: With `load_n` low and the clear inactive, the next rising edge copies `din` into `q`, whatever `en_p` and `en_t` are.
- R3: With `ASYNC_CLR`=0, a low `clr_n` sampled at a rising edge sets `q` to 0 on that edge, overriding `load_n` and both enables.
- R4: With `ASYNC_CLR`=1, a low `clr_n` forces `q` to 0 at once, without a clock edge, and keeps it at 0 while `clr_n` stays low.
- R5: With `clr_n` and `load_n` high and `en_p`=`en_t`=1 at a rising edge, `q` increments by one. It wraps from 15 to 0, so from a preset of 12 it runs 13, 14, 15, 0, 1, 2.
- R6: With `clr_n` and `load_n` high and either enable low, `q` keeps its value across the edge.
- R7: `carry` is 1 exactly when `en_t` is 1 and `q` is all ones. A change on `en_t` reaches `carry` within the same cycle, without a clock edge.
- R8: Two instances, with the low stage's `carry` driving the high stage's `en_t` and a shared enable on both `en_p` pins (the low stage's `en_t` also on that enable), count as one 8-bit counter. The high stage's `carry` is high only at 255.
- R9: With `ASYNC_CLR`=0 and `clr_n` driven low by an external decode of `q`==9, the counter cycles 0 through 9 and back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 0 |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous by parameter |
| load_n | input | 1 | Active-low parallel load |
| en_p | input | 1 | Parallel count enable |
| en_t | input | 1 | Through count enable; also gates the carry |
| din | input | WIDTH | Parallel load data |
| q | output | WIDTH | Counter state |
| carry | output | 1 | High when `en_t` is high and `q` is all ones |

## Verification
The state is itself the output `q`, so a wrong next-state choice (a misordered priority, an enable ignored, a missed wrap) shows on the port one edge after the stimulus. The model in the bench compares `q` on every cycle. A corrupted carry shows either as a pulse away from the all-ones state or as a missing pulse at 15. The cascade exposes it quickly: the high byte steps at the wrong time within one low-stage period. The modulo-10 run catches a clear that takes effect at the wrong edge, because the sequence would show 10 or skip 9 within ten cycles.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } pcnt_mode_e;
endpackage

// File: rtl/pcnt_mode_dec.sv
module pcnt_mode_dec
  import pcnt_pkg::*;
#(
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic       clr_n,
  input  logic       load_n,
  input  logic       en_p,
  input  logic       en_t,
  output pcnt_mode_e mode
);
  logic sync_clr;

  generate
    if (ASYNC_CLR) begin : g_async
      // Clear is handled directly by the state flops.
      assign sync_clr = 1'b0;
    end else begin : g_sync
      assign sync_clr = ~clr_n;
    end
  endgenerate

  always_comb begin
    if (sync_clr)            mode = MODE_CLEAR;
    else if (!load_n)        mode = MODE_LOAD;
    else if (en_p && en_t)   mode = MODE_COUNT;
    else                     mode = MODE_HOLD;
  end
endmodule

// File: rtl/pcnt_state.sv
module pcnt_state
  import pcnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  pcnt_mode_e       mode,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] nxt;

  always_comb begin
    unique case (mode)
      MODE_CLEAR: nxt = '0;
      MODE_LOAD:  nxt = din;
      MODE_COUNT: nxt = q + ONE;
      default:    nxt = q;
    endcase
  end

  generate
    if (ASYNC_CLR) begin : g_async_ff
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)   q <= '0;
        else if (rst) q <= '0;
        else          q <= nxt;
      end
    end else begin : g_sync_ff
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/pcnt_carry.sv
module pcnt_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             carry
);
  localparam logic [WIDTH-1:0] TERMINAL = {WIDTH{1'b1}};

  assign carry = en_t && (q == TERMINAL);
endmodule

// File: rtl/preset_counter.sv
module preset_counter
  import pcnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry
);
  pcnt_mode_e mode;

  pcnt_mode_dec #(.ASYNC_CLR(ASYNC_CLR)) u_dec (
    .clr_n (clr_n),
    .load_n(load_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .mode  (mode)
  );

  pcnt_state #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_state (
    .clk  (clk),
    .rst  (rst),
    .clr_n(clr_n),
    .mode (mode),
    .din  (din),
    .q    (q)
  );

  pcnt_carry #(.WIDTH(WIDTH)) u_carry (
    .q    (q),
    .en_t (en_t),
    .carry(carry)
  );
endmodule

// File: rtl/preset_counter_chk.sv
module preset_counter_chk #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_n,
  input logic             load_n,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             carry
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // With an asynchronous clear, a mid-cycle clear legitimately zeroes q.
  logic aclr_now;
  assign aclr_now = ASYNC_CLR && !clr_n;

  p_reset_r1: assert property (@(posedge clk) rst |=> q == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !load_n) |=> (q == $past(din) || aclr_now));

  p_count_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && en_p && en_t) |=> (q == $past(q) + ONE || aclr_now));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && !(en_p && en_t)) |=> (q == $past(q) || aclr_now));

  p_carry_r7: assert property (@(posedge clk) disable iff (rst)
    carry |-> (en_t && (&q)));

  generate
    if (ASYNC_CLR) begin : g_async_chk
      p_aclr_r4: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> q == '0);
    end else begin : g_sync_chk
      p_sclr_r3: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> q == '0);
    end
  endgenerate
endmodule

bind preset_counter preset_counter_chk #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_chk (
  .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n), .en_p(en_p),
  .en_t(en_t), .din(din), .q(q), .carry(carry)
);

// File: tb/preset_counter_tb.sv
`timescale 1ns/100ps
module preset_counter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // main synchronous-clear instance
  logic clr_n = 1, load_n = 1, en_p = 0, en_t = 0;
  logic [3:0] din = 0, q;
  logic carry;
  preset_counter u_dut (.clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n),
    .en_p(en_p), .en_t(en_t), .din(din), .q(q), .carry(carry));

  // asynchronous-clear instance
  logic a_clr_n = 1, a_load_n = 1, a_p = 0, a_t = 0;
  logic [3:0] a_din = 0, a_q;
  logic a_carry;
  preset_counter #(.ASYNC_CLR(1'b1)) u_dut_async (.clk(clk), .rst(rst),
    .clr_n(a_clr_n), .load_n(a_load_n), .en_p(a_p), .en_t(a_t), .din(a_din),
    .q(a_q), .carry(a_carry));

  // two-stage cascade
  logic c_en = 0;
  logic [3:0] lo_q, hi_q;
  logic lo_c, hi_c;
  preset_counter u_lo (.clk(clk), .rst(rst), .clr_n(1'b1), .load_n(1'b1),
    .en_p(c_en), .en_t(c_en), .din(4'd0), .q(lo_q), .carry(lo_c));
  preset_counter u_hi (.clk(clk), .rst(rst), .clr_n(1'b1), .load_n(1'b1),
    .en_p(c_en), .en_t(lo_c), .din(4'd0), .q(hi_q), .carry(hi_c));

  // modulo-10 via external decode into the synchronous clear
  logic m_en = 0;
  logic [3:0] md_q;
  logic md_c, md_clr_n;
  assign md_clr_n = !(md_q == 4'd9);
  preset_counter u_mod (.clk(clk), .rst(rst), .clr_n(md_clr_n), .load_n(1'b1),
    .en_p(m_en), .en_t(m_en), .din(4'd0), .q(md_q), .carry(md_c));

  typedef struct {
    int         sel;
    logic [7:0] q;
    logic       c;
    string      tag;
  } item_t;
  item_t sbq[$];

  task automatic push(int sel, logic [7:0] eq, logic ec, string tag);
    item_t it;
    it.sel = sel; it.q = eq; it.c = ec; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compare everything expected for this edge
  always @(posedge clk) begin
    #1;
    while (sbq.size() > 0) begin
      item_t it;
      logic [7:0] aq;
      logic ac;
      it = sbq.pop_front();
      case (it.sel)
        0: begin aq = {4'd0, q};         ac = carry; end
        1: begin aq = {hi_q, lo_q};      ac = hi_c;  end
        default: begin aq = {4'd0, md_q}; ac = md_c; end
      endcase
      check(aq == it.q, {it.tag, " q"}, aq, it.q);
      check(ac == it.c, {it.tag, " carry"}, ac, it.c);
    end
  end

  logic [3:0] m_q = 0;
  task automatic main_cyc(logic c, logic l, logic p, logic t, logic [3:0] d, string tag);
    @(negedge clk);
    clr_n = c; load_n = l; en_p = p; en_t = t; din = d;
    if (!c)          m_q = 4'd0;
    else if (!l)     m_q = d;
    else if (p && t) m_q = m_q + 4'd1;
    push(0, {4'd0, m_q}, t && (m_q == 4'hF), tag);
  endtask

  initial begin
    #800000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    if (!finished) begin
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] c_q;
    logic [3:0] mq;
    repeat (2) @(negedge clk);
    push(0, 8'd0, 1'b0, "R1 reset main");
    push(1, 8'd0, 1'b0, "R1 reset cascade");
    @(negedge clk);
    rst = 0;

    // reference sequence and priorities (R2 R3 R5 R6 R7)
    main_cyc(1, 1, 0, 0, 4'd0,  "R6 idle hold");
    main_cyc(0, 1, 1, 1, 4'd0,  "R3 clear");
    main_cyc(1, 0, 0, 0, 4'd12, "R2 preset 12 enables low");
    for (int i = 0; i < 6; i++) main_cyc(1, 1, 1, 1, 4'd0, "R5 count and wrap");
    main_cyc(1, 1, 0, 1, 4'd0,  "R6 en_p low");
    main_cyc(1, 1, 1, 0, 4'd0,  "R6 en_t low");
    main_cyc(1, 0, 1, 1, 4'd15, "R2 load beats count");
    main_cyc(1, 1, 1, 0, 4'd0,  "R7 carry gated by en_t");
    @(posedge clk); #1.5;
    en_t = 1; #0.2;
    check(carry == 1'b1, "R7 en_t rise to carry", carry, 1);
    en_t = 0; #0.1;
    check(carry == 1'b0, "R7 en_t fall to carry", carry, 0);
    main_cyc(1, 1, 0, 1, 4'd0,  "R7 carry without en_p");
    main_cyc(0, 0, 1, 1, 4'd9,  "R3 clear beats load");
    main_cyc(1, 1, 1, 1, 4'd0,  "R5 count after clear");

    // asynchronous clear instance (R4)
    @(negedge clk); a_load_n = 0; a_din = 4'd7;
    @(posedge clk); #1;
    check(a_q == 4'd7, "R2 async-variant load", a_q, 7);
    a_load_n = 1;
    @(posedge clk); #1;
    a_clr_n = 0; #0.5;
    check(a_q == 4'd0, "R4 clear without clock", a_q, 0);
    @(negedge clk); a_load_n = 0; a_din = 4'd5; a_p = 1; a_t = 1;
    @(posedge clk); #1;
    check(a_q == 4'd0, "R4 clear held over load", a_q, 0);
    @(negedge clk); a_clr_n = 1; a_load_n = 1;
    @(posedge clk); #1;
    check(a_q == 4'd1, "R5 async-variant count", a_q, 1);
    @(negedge clk); a_p = 0; a_t = 0;

    // cascade (R8)
    c_q = 0;
    for (int i = 0; i < 260; i++) begin
      @(negedge clk);
      c_en = (i % 7) != 3;
      if (c_en) c_q = c_q + 8'd1;
      push(1, c_q, c_en && (c_q == 8'hFF), "R8 cascade");
    end
    @(negedge clk); c_en = 0;

    // modulo-10 (R9)
    mq = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      m_en = 1;
      if (mq == 4'd9) mq = 4'd0;
      else            mq = mq + 4'd1;
      push(2, {4'd0, mq}, 1'b0, "R9 modulo-10");
    end
    @(negedge clk); m_en = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule